// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block sits on the controller side of a four-wire synchronous serial link and brings a target microcontroller into its serial programming mode. On a start request it pulls the target's reset line low and waits a settling interval. It then sends a fixed four-byte enable request through an attached byte-wide serial master. The target answers in step with the third byte. If that answer is the expected echo, the block signals success and keeps reset low so that later programming commands can follow.

If the echo does not match, the block can send one extra zero byte. This restores four-byte framing in a target that lost a byte. The block then pulses the target reset high between two low intervals and tries again. After a fixed number of attempts it gives up, releases reset and signals failure. The serial master is driven through a request/done handshake, and the block never issues a byte while the master reports busy.

Top module: `prog_entry_seq`

## Requirements
- R1: After reset `tgt_rst_o` is 1 (target released) and `done_o`, `fail_o` and `xfer_req_o` are 0.
- R2: A start while idle drives `tgt_rst_o` low. The first byte request of every attempt appears exactly DELAY_CYC+1 cycles after `tgt_rst_o` last went low (or after the start, if reset was already low).
- R3: Each attempt requests the bytes 0xAC, 0x53, 0x00, 0x00 in that order, presented on `xfer_data_o` while `xfer_req_o` is 1.
- R4: `xfer_req_o` is a one-cycle pulse. It is raised only when `xfer_busy_i` was 0 in the cycle before, and only after `xfer_done_i` has answered the previous request.
- R5: An attempt succeeds exactly when the `xfer_rx_i` byte returned with the third request's `xfer_done_i` equals 0x53. The bytes returned for the first, second and fourth requests have no effect.
- R6: The fourth byte is always requested, including on a match, and `done_o` follows only after its `xfer_done_i`.
- R7: With PAD_EN=1 (default), a failed check that is not the final attempt is followed by one extra request of 0x00 before the reset pulse.
- R8: Between attempts `tgt_rst_o` goes high for exactly DELAY_CYC cycles, preceded and followed by DELAY_CYC-long low intervals. Exactly one pulse follows each failed non-final attempt, and no byte is requested while `tgt_rst_o` is high.
- R9: At most MAX_TRIES attempts are made. After the last failure `fail_o` pulses for one cycle and `tgt_rst_o` returns to 1, with no reset pulse.
- R10: On success `done_o` pulses for exactly one cycle and `tgt_rst_o` stays 0 afterwards.
- R11: A start while a sequence is running has no effect on the byte stream, the attempt count or the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the entry sequence (ignored while running) |
| done_o | output | 1 | One-cycle pulse: target acknowledged |
| fail_o | output | 1 | One-cycle pulse: no answer after all attempts |
| tgt_rst_o | output | 1 | Target reset line level (0 = held in reset) |
| xfer_req_o | output | 1 | One-cycle request to the serial master to shift a byte |
| xfer_data_o | output | 8 | Byte to shift, valid with `xfer_req_o` |
| xfer_busy_i | input | 1 | Serial master is shifting |
| xfer_done_i | input | 1 | One-cycle pulse: transfer finished |
| xfer_rx_i | input | 8 | Byte received during the finished transfer, valid with `xfer_done_i` |

## Verification
The bench sweeps the attempt on which the target first echoes correctly over every value from the first to the last allowed attempt, and adds runs where it never echoes. This shows that the retry bound, the per-attempt padding byte and the one-pulse-per-failure rule hold at every count. In failing attempts the third response cycles through near misses (0x52, 0x13, 0xD3, 0x00, 0xFF, 0xAC), while the other three responses are always 0x53. A design that checks the wrong slot or compares only some bits therefore passes or fails at the wrong attempt. Some runs raise start again in the middle of a sequence to show it is ignored.

// File: rtl/pes_pkg.sv
package pes_pkg;

    localparam int unsigned REQ_LEN   = 4;
    localparam int unsigned ECHO_SLOT = 2;
    localparam logic [7:0]  ECHO_VAL  = 8'h53;
    localparam logic [7:0]  PAD_BYTE  = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SEND,
        ST_WAIT,
        ST_CHECK,
        ST_GAP_PRE,
        ST_PULSE,
        ST_GAP_POST
    } pes_state_e;

    typedef struct packed {
        pes_state_e st;
        logic       rst_lvl;
        logic       req;
        logic [7:0] data;
        logic       pad;
        logic [7:0] echo;
        logic       done;
        logic       fail;
    } pes_regs_t;

    function automatic logic [7:0] entry_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'hAC;
            2'd1:    return 8'h53;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pes_delay.sv
module pes_delay #(
    parameter int unsigned DELAY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);
    localparam int unsigned CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = LOAD_VAL;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R8: interval counter never exceeds the programmed length
    assert_cnt_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL);

endmodule

// File: rtl/pes_tries.sv
module pes_tries #(
    parameter int unsigned MAX_TRIES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int unsigned TW = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0] LAST_VAL = TW'(MAX_TRIES - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST_VAL);

    // R9: the sequencer never asks for an attempt beyond the limit
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !last_o);

    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);

endmodule

// File: rtl/pes_frame.sv
module pes_frame
    import pes_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       adv_i,
    output logic [7:0] byte_o,
    output logic       echo_slot_o,
    output logic       last_o
);
    localparam int unsigned IW = $clog2(REQ_LEN);

    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr_i)
            idx_d = '0;
        else if (adv_i)
            idx_d = idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign byte_o      = entry_byte(idx_q);
    assign echo_slot_o = (idx_q == IW'(ECHO_SLOT));
    assign last_o      = (idx_q == IW'(REQ_LEN - 1));

    // R3: the slot index never advances past the fourth byte
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> !last_o);

endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq
    import pes_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 8,
    parameter int unsigned MAX_TRIES = 32,
    parameter bit          PAD_EN    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       done_o,
    output logic       fail_o,
    output logic       tgt_rst_o,
    output logic       xfer_req_o,
    output logic [7:0] xfer_data_o,
    input  logic       xfer_busy_i,
    input  logic       xfer_done_i,
    input  logic [7:0] xfer_rx_i
);
    pes_regs_t r_d, r_q;

    logic       tmr_load, tmr_zero;
    logic       try_clr, try_inc, try_last;
    logic       fr_clr, fr_adv, fr_echo, fr_last;
    logic [7:0] fr_byte;

    pes_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .zero_o (tmr_zero)
    );

    pes_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (try_clr),
        .inc_i  (try_inc),
        .last_o (try_last)
    );

    pes_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (fr_clr),
        .adv_i       (fr_adv),
        .byte_o      (fr_byte),
        .echo_slot_o (fr_echo),
        .last_o      (fr_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.req  = 1'b0;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        tmr_load = 1'b0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        fr_clr   = 1'b0;
        fr_adv   = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st      = ST_SETTLE;
                    r_d.rst_lvl = 1'b0;
                    r_d.pad     = 1'b0;
                    tmr_load    = 1'b1;
                    try_clr     = 1'b1;
                    fr_clr      = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) r_d.st = ST_SEND;
            end
            ST_SEND: begin
                if (!xfer_busy_i) begin
                    r_d.req  = 1'b1;
                    r_d.data = r_q.pad ? PAD_BYTE : fr_byte;
                    r_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (xfer_done_i) begin
                    if (r_q.pad) begin
                        r_d.pad  = 1'b0;
                        r_d.st   = ST_GAP_PRE;
                        tmr_load = 1'b1;
                    end else begin
                        if (fr_echo) r_d.echo = xfer_rx_i;
                        if (fr_last) begin
                            r_d.st = ST_CHECK;
                        end else begin
                            fr_adv = 1'b1;
                            r_d.st = ST_SEND;
                        end
                    end
                end
            end
            ST_CHECK: begin
                fr_clr = 1'b1;
                if (r_q.echo == ECHO_VAL) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (try_last) begin
                    r_d.fail    = 1'b1;
                    r_d.rst_lvl = 1'b1;
                    r_d.st      = ST_IDLE;
                end else begin
                    try_inc = 1'b1;
                    if (PAD_EN) begin
                        r_d.pad = 1'b1;
                        r_d.st  = ST_SEND;
                    end else begin
                        r_d.st   = ST_GAP_PRE;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_GAP_PRE: begin
                if (tmr_zero) begin
                    r_d.st      = ST_PULSE;
                    r_d.rst_lvl = 1'b1;
                    tmr_load    = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    r_d.st      = ST_GAP_POST;
                    r_d.rst_lvl = 1'b0;
                    tmr_load    = 1'b1;
                end
            end
            ST_GAP_POST: begin
                if (tmr_zero) r_d.st = ST_SEND;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.rst_lvl <= 1'b1;
            r_q.req     <= 1'b0;
            r_q.data    <= '0;
            r_q.pad     <= 1'b0;
            r_q.echo    <= '0;
            r_q.done    <= 1'b0;
            r_q.fail    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o      = r_q.done;
    assign fail_o      = r_q.fail;
    assign tgt_rst_o   = r_q.rst_lvl;
    assign xfer_req_o  = r_q.req;
    assign xfer_data_o = r_q.data;

    // R4: a byte is handed over only when the engine was idle
    assert_req_engine_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> !$past(xfer_busy_i));

    // R4: requests are single-cycle pulses
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |=> !xfer_req_o);

    // R8: no byte while the target reset line is high
    assert_req_rst_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> !tgt_rst_o);

    // R10: success pulse is one cycle and keeps target in reset
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_rst_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !tgt_rst_o);

    // R9: failure releases the target reset line
    assert_fail_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> tgt_rst_o);

    assert_outcome_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

endmodule

// File: tb/tb_prog_entry_seq.sv
`timescale 1ns/1ps
module tb_prog_entry_seq;
    localparam int D    = 8;
    localparam int MAXT = 32;
    localparam int LAT  = 3;
    localparam int WDOG = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy = 1'b0;
    logic       xdone = 1'b0;
    logic [7:0] rx = 8'h00;
    logic       done_o, fail_o, tgt_rst, req;
    logic [7:0] data;

    prog_entry_seq #(.DELAY_CYC(D), .MAX_TRIES(MAXT), .PAD_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done_o), .fail_o(fail_o),
        .tgt_rst_o(tgt_rst), .xfer_req_o(req), .xfer_data_o(data),
        .xfer_busy_i(busy), .xfer_done_i(xdone), .xfer_rx_i(rx));

    always #5 clk = ~clk;

    int nchk = 0, nbad = 0, cyc = 0;
    int slot = 0, attempt = 0, succ_at = 0, nbytes = 0;
    int pulses = 0, fall_cyc = 0, hi_start = 0;
    int done_cnt = 0, fail_cnt = 0, lat_cnt = 0;
    bit pulse_open = 0, busy_phase = 0, running = 0;
    logic prev_rst = 1'b1;
    logic [7:0] bad_val = 8'h00, resp = 8'h00;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int s);
        return (s == 0) ? 8'hAC : (s == 1) ? 8'h53 : 8'h00;
    endfunction

    // Single negedge process: cycle count, reset monitor, serial master model
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WDOG) begin
                check(1'b0, "watchdog", cyc, WDOG);
                $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
                $finish;
            end
            if (rst_n) begin
                if (tgt_rst && !prev_rst && !fail_o) begin
                    pulses++;
                    hi_start   = cyc;
                    pulse_open = 1;
                end
                if (!tgt_rst && prev_rst) begin
                    fall_cyc = cyc;
                    if (pulse_open) begin
                        check(cyc - hi_start == D, "R8 pulse width", cyc - hi_start, D);
                        pulse_open = 0;
                    end
                end
                if (done_o) done_cnt++;
                if (fail_o) fail_cnt++;
            end
            prev_rst = tgt_rst;

            xdone = 1'b0;
            if (busy_phase) begin
                if (lat_cnt == 0) begin
                    xdone = 1'b1;
                    rx    = resp;
                    busy  = 1'b0;
                    busy_phase = 0;
                end else begin
                    lat_cnt--;
                end
            end else if (req) begin
                nbytes++;
                check(1'b1, "R4 engine idle at request", 0, 0);
                check(data == exp_byte(slot), (slot == 4) ? "R7 pad byte" : "R3 byte order",
                      data, exp_byte(slot));
                check(tgt_rst == 1'b0, "R8 reset low during request", tgt_rst, 0);
                if (slot == 0)
                    check(cyc - fall_cyc == D + 1, "R2 settle before attempt", cyc - fall_cyc, D + 1);
                resp = (slot == 2) ? ((attempt + 1 == succ_at) ? 8'h53 : bad_val) : 8'h53;
                busy = 1'b1;
                busy_phase = 1;
                lat_cnt = LAT;
                if (slot == 3) begin
                    if (attempt + 1 != succ_at && attempt + 1 < MAXT) slot = 4;
                    else begin slot = 0; attempt++; end
                end else if (slot == 4) begin
                    slot = 0; attempt++;
                end else begin
                    slot++;
                end
            end
            if (req && busy_phase && lat_cnt != LAT)
                check(1'b0, "R4 request while engine busy", 1, 0);
        end
    end

    task automatic run(input int sa, input logic [7:0] bv, input bit poke);
        int expa;
        int t0;
        expa = (sa == 0) ? MAXT : sa;
        succ_at = sa; bad_val = bv; slot = 0; attempt = 0; nbytes = 0;
        pulses = 0; done_cnt = 0; fail_cnt = 0; pulse_open = 0;
        @(posedge clk); #2;
        start = 1'b1;
        fall_cyc = cyc + 2;   // reset low first seen two negedges later
        @(posedge clk); #2;
        start = 1'b0;
        if (poke) begin
            // R11: a second start while running must change nothing
            while (attempt < 1 && done_cnt + fail_cnt == 0) @(negedge clk);
            @(posedge clk); #2; start = 1'b1;
            @(posedge clk); #2; start = 1'b0;
        end
        t0 = cyc;
        while (done_cnt + fail_cnt == 0 && cyc - t0 < 20000) @(negedge clk);
        repeat (3 * D) @(negedge clk);
        if (sa != 0) begin
            check(attempt == expa, "R5 attempts to success", attempt, expa);
            check(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
            check(fail_cnt == 0, "R5 no fail on success", fail_cnt, 0);
            check(tgt_rst == 1'b0, "R10 reset held low", tgt_rst, 0);
        end else begin
            check(attempt == MAXT, "R9 attempt limit", attempt, MAXT);
            check(fail_cnt == 1, "R9 single fail pulse", fail_cnt, 1);
            check(done_cnt == 0, "R9 no done on failure", done_cnt, 0);
            check(tgt_rst == 1'b1, "R9 reset released", tgt_rst, 1);
        end
        check(pulses == expa - 1, "R8 pulse count", pulses, expa - 1);
        check(nbytes == 4 * expa + (expa - 1), "R6 R7 byte count", nbytes, 5 * expa - 1);
        check(poke ? (done_cnt + fail_cnt == 1) : 1'b1, "R11 start ignored", done_cnt + fail_cnt, 1);
    endtask

    initial begin
        logic [7:0] misses [6];
        misses = '{8'h52, 8'h13, 8'hD3, 8'h00, 8'hFF, 8'hAC};
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(tgt_rst == 1'b1, "R1 reset released", tgt_rst, 1);
        check(done_o == 1'b0 && fail_o == 1'b0, "R1 no outcome", {done_o, fail_o}, 0);
        check(req == 1'b0, "R1 no request", req, 0);
        for (int k = 1; k <= MAXT; k++)
            run(k, misses[k % 6], (k % 4) == 3);
        run(0, 8'h52, 1'b0);
        run(0, 8'hFF, 1'b1);
        run(1, 8'h00, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule